// File: doc/BRIEF.md
# Precision-Scalable Slice-Serial Integer Adder

This block adds two unsigned integer operands of up to `DATA_W` bits at a precision chosen per operation. With each operand pair the caller supplies how many most-significant bits matter. The block rounds that count up to a whole number of slices and drops every operand bit below the kept region. It then adds the kept bits through an adder only `SLICE_W` bits wide, one slice per clock, starting with the least significant kept slice. A registered carry links each slice to the next.

The partial sums are shifted into a full-width accumulator, so the result comes out aligned at full width, with zeros below the kept region. A carry out of the top slice is reported as an overflow flag. Latency therefore tracks the requested precision: a low-precision add costs fewer cycles than a full-width one. The slice width is fixed at elaboration and must be a power of two. Setting it to `DATA_W` gives an ordinary single-cycle adder.

Top module: `psa_adder`

## Requirements
- R1: `prec_i` is sampled on the acceptance edge. A value from 1 to `DATA_W` keeps k = ceil(prec_i / SLICE_W) slices. A value of 0, or one above `DATA_W`, keeps all `DATA_W/SLICE_W` slices. The kept region is bits `DATA_W-1` down to `DATA_W-k*SLICE_W`.
- R2: Operand bits below the kept region do not affect `result_o` or `overflow_o`.
- R3: `result_o` equals (a_kept + b_kept) mod 2^DATA_W, where x_kept is the operand with the bits below the kept region set to zero. The bits of `result_o` below the kept region are therefore zero.
- R4: `overflow_o` is the carry out of bit `DATA_W-1` of that kept-bit sum.
- R5: `res_valid_o` is high for exactly one cycle. It rises k rising edges after the acceptance edge.
- R6: `in_ready_o` is low from the cycle after acceptance until the result cycle, and high in the result cycle. `in_valid_i` and the operand inputs are ignored while `in_ready_o` is low.
- R7: A carry produced in one slice is added into the next higher slice of the same operation, and the carry is cleared at the start of every operation.
- R8: After reset, `in_ready_o` is 1, `res_valid_o` is 0, `result_o` is 0 and `overflow_o` is 0.
- R9: `result_o` and `overflow_o` hold their values from the result cycle until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair offered |
| in_ready_o | output | 1 | Block idle and able to accept operands |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B |
| prec_i | input | $clog2(DATA_W+1) | Requested precision, in most-significant bits |
| res_valid_o | output | 1 | One-cycle pulse: result and overflow are fresh |
| result_o | output | DATA_W | Sum, aligned at full width |
| overflow_o | output | 1 | Carry out of the top kept slice |

## Verification
The bench targets carries that must cross slice boundaries: an all-ones operand plus one, and a value whose kept region ends in 0xFF plus one. A design that dropped or stuck the inter-slice carry would return a broken sum or a wrong overflow flag. It also sends operand pairs that agree in their kept region but differ below it, and precisions that are not slice multiples, 0, or above the width. Any error in rounding or in the zero/over-range encoding shows up as a wrong latency or as stray low bits in the result.

Extra operand pairs are offered while the block is busy. A design that accepted them would corrupt the operation in flight or add an extra result. Results are also checked to stay put after the valid pulse; a design that kept shifting its accumulator would change them.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} psa_state_e;

  // slices kept for a requested precision; 0 or over-range selects full width
  function automatic int kept_slices(int prec, int data_w, int slice_w);
    int p;
    p = (prec == 0 || prec > data_w) ? data_w : prec;
    return (p + slice_w - 1) / slice_w;
  endfunction

endpackage

// File: rtl/psa_quant.sv
module psa_quant #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  localparam int NUM_SL  = DATA_W / SLICE_W,
  localparam int CNT_W   = $clog2(NUM_SL + 1),
  localparam int PREC_W  = $clog2(DATA_W + 1),
  localparam int SLICE_LG = $clog2(SLICE_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [PREC_W-1:0] prec_i,
  output logic [DATA_W-1:0] a_kept_o,
  output logic [DATA_W-1:0] b_kept_o,
  output logic [CNT_W-1:0]  n_slices_o
);

  logic [CNT_W-1:0]  skip_sl;
  logic [PREC_W-1:0] shamt;

  always_comb begin
    n_slices_o = CNT_W'(psa_pkg::kept_slices(int'(prec_i), DATA_W, SLICE_W));
    skip_sl    = CNT_W'(NUM_SL) - n_slices_o;
    shamt      = PREC_W'(skip_sl) << SLICE_LG;
    // kept bits moved to the bottom so the serializer starts at bit 0
    a_kept_o   = a_i >> shamt;
    b_kept_o   = b_i >> shamt;
  end

endmodule

// File: rtl/psa_serializer.sv
module psa_serializer #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [SLICE_W-1:0] a_sl_o,
  output logic [SLICE_W-1:0] b_sl_o
);

  logic [DATA_W-1:0] a_sh_q, b_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh_q <= '0;
      b_sh_q <= '0;
    end else if (load_i) begin
      a_sh_q <= a_i;
      b_sh_q <= b_i;
    end else if (shift_i) begin
      a_sh_q <= a_sh_q >> SLICE_W;
      b_sh_q <= b_sh_q >> SLICE_W;
    end
  end

  assign a_sl_o = a_sh_q[SLICE_W-1:0];
  assign b_sl_o = b_sh_q[SLICE_W-1:0];

endmodule

// File: rtl/psa_slice_add.sv
module psa_slice_add #(
  parameter int SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               carry_o
);

  logic               carry_q;
  logic [SLICE_W:0]   full;

  assign full  = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, carry_q};
  assign sum_o = full[SLICE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     carry_q <= 1'b0;
    else if (clr_i)  carry_q <= 1'b0;
    else if (en_i)   carry_q <= full[SLICE_W];
  end

  assign carry_o = carry_q;

endmodule

// File: rtl/psa_deser.sv
module psa_deser #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [SLICE_W-1:0] sum_i,
  output logic [DATA_W-1:0]  acc_o
);

  logic [DATA_W-1:0] acc_q, acc_d;

  // slices enter at the top; after k shifts they sit in the kept region
  generate
    if (SLICE_W == DATA_W) begin : g_single
      assign acc_d = sum_i;
    end else begin : g_shift
      assign acc_d = {sum_i, acc_q[DATA_W-1:SLICE_W]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/psa_adder.sv
module psa_adder #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  localparam int NUM_SL = DATA_W / SLICE_W,
  localparam int CNT_W  = $clog2(NUM_SL + 1),
  localparam int PREC_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [PREC_W-1:0] prec_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              overflow_o
);

  import psa_pkg::*;

  psa_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               res_valid_q;
  logic               accept, step, last;
  logic [DATA_W-1:0]  a_kept, b_kept;
  logic [CNT_W-1:0]   n_slices;
  logic [SLICE_W-1:0] a_sl, b_sl, sum_sl;
  logic               carry;

  assign accept = in_valid_i && (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);
  assign last   = step && (cnt_q == CNT_W'(1));

  psa_quant #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) quant_i (
    .a_i        (a_i),
    .b_i        (b_i),
    .prec_i     (prec_i),
    .a_kept_o   (a_kept),
    .b_kept_o   (b_kept),
    .n_slices_o (n_slices)
  );

  psa_serializer #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) ser_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (step),
    .a_i     (a_kept),
    .b_i     (b_kept),
    .a_sl_o  (a_sl),
    .b_sl_o  (b_sl)
  );

  psa_slice_add #(.SLICE_W(SLICE_W)) add_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .en_i    (step),
    .a_i     (a_sl),
    .b_i     (b_sl),
    .sum_o   (sum_sl),
    .carry_o (carry)
  );

  psa_deser #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) deser_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (step),
    .sum_i  (sum_sl),
    .acc_o  (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= last;
      if (accept) begin
        state_q <= ST_RUN;
        cnt_q   <= n_slices;
      end else if (step) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last) state_q <= ST_IDLE;
      end
    end
  end

  assign in_ready_o  = (state_q == ST_IDLE);
  assign res_valid_o = res_valid_q;
  assign overflow_o  = carry;

endmodule

// File: rtl/psa_adder_chk.sv
module psa_adder_chk #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8,
  localparam int NUM_SL = DATA_W / SLICE_W,
  localparam int CNT_W  = $clog2(NUM_SL + 1),
  localparam int PREC_W = $clog2(DATA_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [PREC_W-1:0] prec_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              overflow_o
);

  logic              acc_ev;
  logic [CNT_W-1:0]  chk_cnt;
  logic [CNT_W-1:0]  k_c;
  logic [DATA_W:0]   ref_sum_c, ref_sum_q;
  logic [DATA_W-1:0] mask_c;

  assign acc_ev = in_valid_i && in_ready_o;

  always_comb begin
    int p;
    int k;
    p = int'(prec_i);
    if (p == 0 || p > DATA_W) p = DATA_W;
    k = (p + SLICE_W - 1) / SLICE_W;
    k_c = CNT_W'(k);
    mask_c = ~({DATA_W{1'b0}}) << (DATA_W - k * SLICE_W);
    ref_sum_c = {1'b0, a_i & mask_c} + {1'b0, b_i & mask_c};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt   <= '0;
      ref_sum_q <= '0;
    end else if (acc_ev) begin
      chk_cnt   <= k_c;
      ref_sum_q <= ref_sum_c;
    end else if (chk_cnt != '0) begin
      chk_cnt <= chk_cnt - CNT_W'(1);
    end
  end

  // R3 (covers R1, R2, R7)
  assert_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> result_o == ref_sum_q[DATA_W-1:0]);

  assert_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> overflow_o == ref_sum_q[DATA_W]);

  assert_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_cnt == CNT_W'(1)) |=> res_valid_o);

  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_cnt != '0) |-> !in_ready_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_cnt == '0 && !acc_ev) |=> $stable(result_o) && $stable(overflow_o));

endmodule

bind psa_adder psa_adder_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .a_i         (a_i),
  .b_i         (b_i),
  .prec_i      (prec_i),
  .res_valid_o (res_valid_o),
  .result_o    (result_o),
  .overflow_o  (overflow_o)
);

// File: tb/psa_adder_tb_top.sv
module psa_adder_tb_top;

  localparam int DATA_W  = 64;
  localparam int SLICE_W = 8;
  localparam int PREC_W  = $clog2(DATA_W + 1);

  typedef struct {
    logic [DATA_W-1:0] res;
    logic              ovf;
    int                acc_cyc;
    int                lat;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] a = '0, b = '0;
  logic [PREC_W-1:0] prec = '0;
  logic              res_valid;
  logic [DATA_W-1:0] result;
  logic              overflow;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  exp_t sb_q[$];
  logic [DATA_W-1:0] last_res = '0;
  logic              last_ovf = 1'b0;
  logic [63:0]       rnd = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psa_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .prec_i(prec),
    .res_valid_o(res_valid), .result_o(result), .overflow_o(overflow)
  );

  task automatic check(input bit ok, input string tag, input logic [DATA_W:0] act,
                       input logic [DATA_W:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                 input int p, input string tag);
    exp_t e;
    int peff, k;
    logic [DATA_W-1:0] mk;
    logic [DATA_W:0] s;
    peff = (p == 0 || p > DATA_W) ? DATA_W : p;
    k = (peff + SLICE_W - 1) / SLICE_W;
    mk = '1;
    mk = mk << (DATA_W - k * SLICE_W);
    s = {1'b0, x & mk} + {1'b0, y & mk};
    e.res = s[DATA_W-1:0];
    e.ovf = s[DATA_W];
    e.lat = k;
    e.tag = tag;
    e.acc_cyc = 0;
    return e;
  endfunction

  task automatic send(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                      input int p, input string tag);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a = x; b = y; prec = PREC_W'(p); in_valid = 1'b1;
    e = model(x, y, p, tag);
    e.acc_cyc = cyc + 1;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R5 unexpected result", {overflow, result}, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(result === e.res, {e.tag, " R3 sum"}, {1'b0, result}, {1'b0, e.res});
        check(overflow === e.ovf, {e.tag, " R4 overflow"}, {{DATA_W{1'b0}}, overflow},
              {{DATA_W{1'b0}}, e.ovf});
        check(cyc - e.acc_cyc == e.lat, {e.tag, " R5 latency"}, (DATA_W+1)'(cyc - e.acc_cyc),
              (DATA_W+1)'(e.lat));
        last_res = result;
        last_ovf = overflow;
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && res_valid === 1'b0, "R8 reset handshake",
          {{(DATA_W-1){1'b0}}, in_ready, res_valid}, {{(DATA_W-1){1'b0}}, 2'b10});
    check(result === '0 && overflow === 1'b0, "R8 reset result", {overflow, result}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64, "R7 full ripple");
    send(64'h12AB_CDEF_0000_1111, 64'h34FF_FFFF_FFFF_FFFF, 8, "R1 one slice");
    send(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0, "R1 zero prec");
    send(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 100, "R1 over-range prec");
    send(64'h00FF_1234_5678_9ABC, 64'h0001_FFFF_FFFF_FFFF, 9, "R7 carry 9b");
    send(64'hABCD_0000_0000_0000, 64'h1111_0000_0000_0000, 16, "R2 base");
    send(64'hABCD_FFFF_1234_5678, 64'h1111_8765_4321_FFFF, 16, "R2 low bits differ");
    send(64'h80FF_FFFF_FFFF_FFFF, 64'h80FF_FFFF_FFFF_FFFF, 8, "R4 overflow 1 slice");
    send(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 63, "R7 carry to MSB");

    // R6: offers while busy are ignored
    send(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64, "R6 busy base");
    a = 64'hDEAD_BEEF_DEAD_BEEF; b = 64'hFFFF_FFFF_FFFF_FFFF; prec = PREC_W'(8);
    in_valid = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b0, "R6 ready low while busy", {{DATA_W{1'b0}}, in_ready}, '0);
    @(negedge clk);
    in_valid = 1'b0;

    for (int i = 0; i < 24; i++) begin
      logic [DATA_W-1:0] x, y;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 7); rnd = rnd ^ (rnd << 17);
      x = rnd;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 7); rnd = rnd ^ (rnd << 17);
      y = rnd;
      send(x, y, (i % 5 == 0) ? 0 : int'(rnd[5:0]) + 1, "R3 mixed");
    end

    while (sb_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(result === last_res && overflow === last_ovf, "R9 hold",
          {overflow, result}, {last_ovf, last_res});
    check(res_valid === 1'b0 && in_ready === 1'b1, "R6 idle after drain",
          {{(DATA_W-1){1'b0}}, in_ready, res_valid}, {{(DATA_W-1){1'b0}}, 2'b10});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule